// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects a set of interrupt request lines from peripherals and offers at most one of them to a single processor. Each request line carries its own enable bit and its own priority level. Both are loaded through a one-entry-per-cycle configuration write port. Among the lines that are both asserted and enabled, the most urgent one is chosen, where a larger number is more urgent. The processor interrupt is raised only when that choice is strictly more urgent than the level the processor is currently running at.

When the processor acknowledges, the block captures the chosen line's index as the vector. In the same clock edge it raises the operating level to that line's priority and saves the previous level on an internal stack. An end-of-interrupt strobe restores the saved level, so service routines can nest up to the full range of priority values. Sticky flags record a pop from an empty stack and a push onto a full one.

Top module: `nested_irq_ctrl`

## Requirements
- R1: A synchronous active-low reset clears `irq_o`, `vector_o`, `cur_prio_o`, `underflow_o` and `overflow_o` to 0. It also disables every input and sets every input's priority to 0.
- R2: A cycle with `cfg_we` high writes `cfg_en` and `cfg_prio` into the entry selected by `cfg_idx`. The new values take part in arbitration from the next clock edge onward.
- R3: An input whose enable bit is 0 has no effect on `irq_o`, on the vector or on the operating priority, whatever its request level and priority.
- R4: Among the inputs that are asserted and enabled, the one with the numerically largest priority wins. On a tie, the lowest-numbered input wins.
- R5: `irq_o` is a registered level. After each clock edge it is 1 exactly when the winner's priority, taken from the inputs and configuration seen at that edge, is strictly greater than the operating priority that holds after that edge. An equal or lower priority never interrupts, so priority 0 never interrupts.
- R6: An acknowledge (`ack_i`) is accepted only while `irq_o` is 1 and a winner strictly above the operating priority is present. An accepted acknowledge loads `vector_o` with the winner's input index. `vector_o` keeps that value until the next accepted acknowledge.
- R7: An accepted acknowledge sets `cur_prio_o` to the winner's priority and pushes the previous operating priority. `irq_o` is 0 in the following cycle unless a strictly higher request is pending.
- R8: `eoi_i` pops the most recently pushed priority into `cur_prio_o`. If an acknowledge is accepted in the same cycle, the acknowledge takes effect and the end-of-interrupt is ignored.
- R9: `eoi_i` with an empty stack sets `cur_prio_o` to 0 and sets `underflow_o`. `underflow_o` stays 1 until reset.
- R10: The stack holds 15 entries, so 15 nested acknowledges at priorities 1 to 15 fit without loss. A push onto a full stack is dropped and sets `overflow_o`, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req_i | input | 16 | Interrupt request level per input |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 4 | Input index written by the configuration port |
| cfg_en | input | 1 | Enable bit value to write |
| cfg_prio | input | 4 | Priority value to write |
| ack_i | input | 1 | Processor acknowledge |
| eoi_i | input | 1 | End-of-interrupt strobe |
| irq_o | output | 1 | Interrupt request to the processor |
| vector_o | output | 4 | Index of the most recently acknowledged input |
| cur_prio_o | output | 4 | Current operating priority |
| underflow_o | output | 1 | Sticky flag: end-of-interrupt with an empty stack |
| overflow_o | output | 1 | Sticky flag: push onto a full stack |

## Verification
The following properties are checked on every clock:
- reset clears the outputs;
- the underflow and overflow flags stay set once set;
- the vector holds still unless an acknowledge is accepted;
- an accepted acknowledge strictly raises the operating priority;
- a pop from a non-empty stack strictly lowers it;
- a raised interrupt never coexists with the top operating priority.

Only the bench's scenarios, compared each cycle against a behavioural model, can show the rest:
- the tie rule and the exclusion of disabled inputs;
- the one-cycle latency of configuration writes;
- the exact cycle in which `irq_o` drops after an acknowledge;
- acknowledge winning over a simultaneous end-of-interrupt;
- a full 15-level nest unwinding in order.

// File: rtl/irqc_pkg.sv
// Shared types for the nested interrupt controller.
// Assumes: only one stack operation per cycle.
package irqc_pkg;
    typedef enum logic [1:0] {
        STK_HOLD = 2'd0,
        STK_PUSH = 2'd1,
        STK_POP  = 2'd2
    } stk_op_e;
endpackage

// File: rtl/irqc_cfg_bank.sv
// Per-input enable and priority registers, written one entry per cycle.
// Assumes: wr_idx < N_IRQ whenever wr_en is high.
module irqc_cfg_bank #(
    parameter int N_IRQ  = 16,
    parameter int PRIO_W = 4,
    parameter int IDX_W  = $clog2(N_IRQ)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic                    wr_enable_bit,
    input  logic [PRIO_W-1:0]       wr_prio,
    output logic [N_IRQ-1:0]        en_o,
    output logic [N_IRQ*PRIO_W-1:0] prio_o
);
    for (genvar g = 0; g < N_IRQ; g++) begin : g_entry
        logic              en_q;
        logic [PRIO_W-1:0] prio_q;

        // Load this entry when the write port selects it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q   <= 1'b0;
                prio_q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                en_q   <= wr_enable_bit;
                prio_q <= wr_prio;
            end
        end

        assign en_o[g]                   = en_q;
        assign prio_o[g*PRIO_W +: PRIO_W] = prio_q;
    end
endmodule

// File: rtl/irqc_arbiter.sv
// Combinational selection of the most urgent asserted and enabled input.
// Assumes: a larger priority value is more urgent; on a tie the lower index wins.
module irqc_arbiter #(
    parameter int N_IRQ  = 16,
    parameter int PRIO_W = 4,
    parameter int IDX_W  = $clog2(N_IRQ)
) (
    input  logic [N_IRQ-1:0]        req_i,
    input  logic [N_IRQ-1:0]        en_i,
    input  logic [N_IRQ*PRIO_W-1:0] prio_i,
    output logic                    win_valid_o,
    output logic [IDX_W-1:0]        win_idx_o,
    output logic [PRIO_W-1:0]       win_prio_o
);
    logic [N_IRQ-1:0] elig;

    // An input competes only when it is requesting and enabled.
    always_comb elig = req_i & en_i;

    // Linear scan: a later entry replaces the best only when strictly more urgent.
    always_comb begin
        win_valid_o = 1'b0;
        win_idx_o   = '0;
        win_prio_o  = '0;
        for (int i = 0; i < N_IRQ; i++) begin
            if (elig[i] && (!win_valid_o || (prio_i[i*PRIO_W +: PRIO_W] > win_prio_o))) begin
                win_valid_o = 1'b1;
                win_idx_o   = IDX_W'(i);
                win_prio_o  = prio_i[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/irqc_prio_stack.sv
// LIFO of saved operating priorities with sticky overflow and underflow flags.
// Assumes: DEPTH >= 2; a push onto a full stack or a pop from an empty one is dropped.
module irqc_prio_stack
    import irqc_pkg::*;
#(
    parameter int DEPTH  = 15,
    parameter int PRIO_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  stk_op_e           op_i,
    input  logic [PRIO_W-1:0] push_val_i,
    output logic [PRIO_W-1:0] top_o,
    output logic              empty_o,
    output logic              ovf_o,
    output logic              unf_o
);
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int ADDR_W = $clog2(DEPTH);

    logic [PRIO_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  top_idx;
    logic              full;

    // Occupancy decode and read address of the newest entry.
    always_comb begin
        empty_o = (cnt_q == '0);
        full    = (cnt_q == CNT_W'(DEPTH));
        top_idx = cnt_q - 1'b1;
        top_o   = empty_o ? '0 : mem[top_idx[ADDR_W-1:0]];
    end

    // Entry storage: written only on a push that fits.
    always_ff @(posedge clk) begin
        if (rst_n && (op_i == STK_PUSH) && !full) begin
            mem[cnt_q[ADDR_W-1:0]] <= push_val_i;
        end
    end

    // Depth counter and sticky error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_o <= 1'b0;
            unf_o <= 1'b0;
        end else begin
            unique case (op_i)
                STK_PUSH: if (full)    ovf_o <= 1'b1; else cnt_q <= cnt_q + 1'b1;
                STK_POP:  if (empty_o) unf_o <= 1'b1; else cnt_q <= cnt_q - 1'b1;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/nested_irq_ctrl.sv
// Nested priority interrupt controller: arbitrates enabled requests and
// raises the processor interrupt only above the current operating priority.
// An acknowledge raises that priority and saves the old one; an
// end-of-interrupt restores it.
// Assumes: the processor holds ack_i for one cycle per accepted interrupt.
module nested_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int N_IRQ     = 16,
    parameter int PRIO_W    = 4,
    parameter int STK_DEPTH = 15,
    parameter int IDX_W     = $clog2(N_IRQ)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IRQ-1:0]  irq_req_i,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic              cfg_en,
    input  logic [PRIO_W-1:0] cfg_prio,
    input  logic              ack_i,
    input  logic              eoi_i,
    output logic              irq_o,
    output logic [IDX_W-1:0]  vector_o,
    output logic [PRIO_W-1:0] cur_prio_o,
    output logic              underflow_o,
    output logic              overflow_o
);
    logic [N_IRQ-1:0]        en_vec;
    logic [N_IRQ*PRIO_W-1:0] prio_vec;
    logic                    win_valid;
    logic [IDX_W-1:0]        win_idx;
    logic [PRIO_W-1:0]       win_prio;
    logic                    win_gt;
    logic                    ack_take;
    stk_op_e                 stk_op;
    logic [PRIO_W-1:0]       stk_top;
    logic                    stk_empty;
    logic [PRIO_W-1:0]       prio_next;
    logic                    irq_q;
    logic [IDX_W-1:0]        vec_q;
    logic [PRIO_W-1:0]       cur_q;

    irqc_cfg_bank #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_cfg (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (cfg_we),
        .wr_idx        (cfg_idx),
        .wr_enable_bit (cfg_en),
        .wr_prio       (cfg_prio),
        .en_o          (en_vec),
        .prio_o        (prio_vec)
    );

    irqc_arbiter #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_arb (
        .req_i       (irq_req_i),
        .en_i        (en_vec),
        .prio_i      (prio_vec),
        .win_valid_o (win_valid),
        .win_idx_o   (win_idx),
        .win_prio_o  (win_prio)
    );

    irqc_prio_stack #(.DEPTH(STK_DEPTH), .PRIO_W(PRIO_W)) u_stk (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_i       (stk_op),
        .push_val_i (cur_q),
        .top_o      (stk_top),
        .empty_o    (stk_empty),
        .ovf_o      (overflow_o),
        .unf_o      (underflow_o)
    );

    // Accept decision, stack operation and next operating priority.
    always_comb begin
        win_gt   = win_valid && (win_prio > cur_q);
        ack_take = ack_i && irq_q && win_gt;
        if (ack_take) begin
            stk_op    = STK_PUSH;
            prio_next = win_prio;
        end else if (eoi_i) begin
            stk_op    = STK_POP;
            prio_next = stk_empty ? '0 : stk_top;
        end else begin
            stk_op    = STK_HOLD;
            prio_next = cur_q;
        end
    end

    // Operating priority, registered interrupt level and captured vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
            irq_q <= 1'b0;
            vec_q <= '0;
        end else begin
            cur_q <= prio_next;
            irq_q <= win_valid && (win_prio > prio_next);
            if (ack_take) vec_q <= win_idx;
        end
    end

    assign irq_o      = irq_q;
    assign vector_o   = vec_q;
    assign cur_prio_o = cur_q;
endmodule

// File: rtl/nested_irq_ctrl_checker.sv
// Cycle properties of the nested interrupt controller, bound to its top.
// Assumes: reset is synchronous and active low.
module nested_irq_ctrl_checker #(
    parameter int PRIO_W = 4,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_o,
    input logic [IDX_W-1:0]  vector_o,
    input logic [PRIO_W-1:0] cur_prio_o,
    input logic              underflow_o,
    input logic              overflow_o,
    input logic              ack_take,
    input logic              eoi_i,
    input logic              stk_empty
);
    localparam logic [PRIO_W-1:0] PRIO_MAX = '1;

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (!irq_o && cur_prio_o == '0 && vector_o == '0 && !underflow_o && !overflow_o));

    assert_no_irq_at_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (cur_prio_o != PRIO_MAX));

    assert_vector_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_take |=> $stable(vector_o));

    assert_ack_raises_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_take |=> (cur_prio_o > $past(cur_prio_o)));

    assert_pop_lowers_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_i && !ack_take && !stk_empty) |=> (cur_prio_o < $past(cur_prio_o)));

    assert_underflow_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_o |=> underflow_o);

    assert_overflow_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |=> overflow_o);
endmodule

bind nested_irq_ctrl nested_irq_ctrl_checker #(.PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_o       (irq_o),
    .vector_o    (vector_o),
    .cur_prio_o  (cur_prio_o),
    .underflow_o (underflow_o),
    .overflow_o  (overflow_o),
    .ack_take    (ack_take),
    .eoi_i       (eoi_i),
    .stk_empty   (stk_empty)
);

// File: tb/nested_irq_ctrl_test.sv
// Bench: a behavioural model is stepped at every rising edge and compared
// with the outputs at every falling edge; directed scenarios add named checks.
module nested_irq_ctrl_test;
    localparam int N = 16;
    localparam int WATCHDOG = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] irq_req = '0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic        cfg_en = 1'b0;
    logic [3:0]  cfg_prio = '0;
    logic        ack = 1'b0;
    logic        eoi = 1'b0;
    logic        irq_o;
    logic [3:0]  vector_o;
    logic [3:0]  cur_prio_o;
    logic        underflow_o;
    logic        overflow_o;

    int checks = 0;
    int fails = 0;
    int cycles = 0;

    // Reference model state.
    int m_en[N];
    int m_pr[N];
    int m_cur = 0;
    int m_irq = 0;
    int m_vec = 0;
    int m_unf = 0;
    int m_ovf = 0;
    int m_stack[$];

    nested_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .irq_req_i(irq_req),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en), .cfg_prio(cfg_prio),
        .ack_i(ack), .eoi_i(eoi), .irq_o(irq_o), .vector_o(vector_o),
        .cur_prio_o(cur_prio_o), .underflow_o(underflow_o), .overflow_o(overflow_o)
    );

    always #10 clk = ~clk;

    // Model step at each rising edge, following the requirements.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin m_en[i] = 0; m_pr[i] = 0; end
            m_cur = 0; m_irq = 0; m_vec = 0; m_unf = 0; m_ovf = 0;
            m_stack.delete();
        end else begin
            int best;
            int wp;
            int ncur;
            bit take;
            best = -1;
            for (int i = 0; i < N; i++)
                if (irq_req[i] && m_en[i] != 0 && (best < 0 || m_pr[i] > m_pr[best])) best = i;
            wp = (best >= 0) ? m_pr[best] : 0;
            take = ack && (m_irq != 0) && (best >= 0) && (wp > m_cur);
            if (take) begin
                if (m_stack.size() < 15) m_stack.push_back(m_cur); else m_ovf = 1;
                m_vec = best;
                ncur = wp;
            end else if (eoi) begin
                if (m_stack.size() == 0) begin ncur = 0; m_unf = 1; end
                else ncur = m_stack.pop_back();
            end else begin
                ncur = m_cur;
            end
            m_irq = (best >= 0 && wp > ncur) ? 1 : 0;
            if (cfg_we) begin m_en[cfg_idx] = cfg_en; m_pr[cfg_idx] = cfg_prio; end
            m_cur = ncur;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            fails++;
            $display("FAIL watchdog R1 actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        chk(irq_o == m_irq[0], "R5 irq_o vs model", irq_o, m_irq);
        chk(vector_o == m_vec[3:0], "R6 vector_o vs model", vector_o, m_vec);
        chk(cur_prio_o == m_cur[3:0], "R7 cur_prio_o vs model", cur_prio_o, m_cur);
        chk(underflow_o == m_unf[0], "R9 underflow_o vs model", underflow_o, m_unf);
        chk(overflow_o == m_ovf[0], "R10 overflow_o vs model", overflow_o, m_ovf);
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(input int idx, input int en, input int p);
        cfg_we = 1'b1; cfg_idx = idx[3:0]; cfg_en = en[0]; cfg_prio = p[3:0];
        cyc();
        cfg_we = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; irq_req = '0; ack = 0; eoi = 0; cfg_we = 0;
        cyc(); cyc();
        rst_n = 1'b1;
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // R1: reset state
        chk(irq_o == 0 && vector_o == 0 && cur_prio_o == 0, "R1 reset outputs", {irq_o, vector_o, cur_prio_o}, 0);
        chk(underflow_o == 0 && overflow_o == 0, "R1 reset flags", {underflow_o, overflow_o}, 0);
        irq_req = '1; cyc(); cyc();
        chk(irq_o == 0, "R1 all inputs disabled after reset", irq_o, 0);
        irq_req = '0;

        // Tie, disabled high-priority input, zero-priority input.
        wr(3, 1, 5); wr(7, 1, 5); wr(9, 0, 12); wr(2, 1, 0);
        irq_req = '0; irq_req[2] = 1; irq_req[3] = 1; irq_req[7] = 1; irq_req[9] = 1;
        cyc();
        chk(irq_o == 1, "R5 irq raised above level 0", irq_o, 1);
        ack = 1; cyc(); ack = 0;
        chk(vector_o == 3, "R4 tie goes to lower index / R3 disabled 9 ignored", vector_o, 3);
        chk(cur_prio_o == 5, "R7 level raised to winner", cur_prio_o, 5);
        chk(irq_o == 0, "R7 irq drops after ack with equal pending", irq_o, 0);

        // R2: enabling input 9 reaches arbitration one edge after the write.
        wr(9, 1, 12);
        chk(irq_o == 0, "R2 write not yet seen at its own edge", irq_o, 0);
        cyc();
        chk(irq_o == 1, "R2 write seen on next edge", irq_o, 1);

        // R8: ack wins over a simultaneous eoi.
        ack = 1; eoi = 1; cyc(); ack = 0; eoi = 0;
        chk(cur_prio_o == 12 && vector_o == 9, "R8 ack beats eoi", cur_prio_o, 12);
        eoi = 1; cyc();
        chk(cur_prio_o == 5, "R8 pop restores 5", cur_prio_o, 5);
        cyc();
        chk(cur_prio_o == 0, "R8 pop restores 0", cur_prio_o, 0);
        cyc(); eoi = 0;
        chk(underflow_o == 1 && cur_prio_o == 0, "R9 empty pop sets underflow", underflow_o, 1);

        // R6: acknowledge ignored while nothing is raised.
        irq_req = '0; cyc(); cyc();
        ack = 1; cyc(); ack = 0;
        chk(vector_o == 9 && cur_prio_o == 0, "R6 spurious ack ignored", vector_o, 9);
        cyc();
        chk(underflow_o == 1, "R9 underflow sticky", underflow_o, 1);

        // R10: a full 15-level nest and its unwinding.
        do_reset();
        for (int p = 1; p < 16; p++) wr(p, 1, p);
        for (int p = 1; p < 16; p++) begin
            irq_req[p] = 1'b1;
            cyc();
            ack = 1; cyc(); ack = 0;
            chk(vector_o == p[3:0] && cur_prio_o == p[3:0], "R7 nested ack level", cur_prio_o, p);
        end
        chk(overflow_o == 0 && cur_prio_o == 15, "R10 fifteen levels fit", overflow_o, 0);
        irq_req = '0;
        for (int p = 14; p >= 0; p--) begin
            eoi = 1; cyc(); eoi = 0;
            chk(cur_prio_o == p[3:0], "R8 unwind order", cur_prio_o, p);
        end
        chk(underflow_o == 0, "R9 no underflow on balanced unwind", underflow_o, 0);
        eoi = 1; cyc(); eoi = 0;
        chk(underflow_o == 1, "R9 extra eoi underflows", underflow_o, 1);

        // Mixed random traffic against the model (R2 to R9).
        do_reset();
        for (int k = 0; k < 4000; k++) begin
            irq_req = N'($urandom);
            ack = ($urandom_range(0, 2) == 0);
            eoi = ($urandom_range(0, 3) == 0);
            if ($urandom_range(0, 7) == 0) begin
                cfg_we = 1; cfg_idx = 4'($urandom); cfg_en = 1'($urandom); cfg_prio = 4'($urandom);
            end else begin
                cfg_we = 0;
            end
            cyc();
        end
        ack = 0; eoi = 0; cfg_we = 0;
        cyc();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule